// File: doc/BRIEF.md
# Bus Request/Grant Controller

This block lets an external master take over a processor's external memory bus. The master pulls an active-low request line low at any time, with no relation to the processor clock. The block brings that level into the clock domain and waits until it has been seen for long enough to count as real. It then releases the processor's memory select and read/write strobes, and only after that drives the active-low grant. When the master lets the request go, the grant is removed first. The strobes are driven again one clock later.

A status output tells the core that it does not own the bus, so the core can stall its external accesses. Every pin is a plain level, so no valid/ready flow control applies. The request is a level, not a transfer, and the block never pushes back on it. A parameter sets the synchroniser depth. A second parameter sets how many consecutive synchronised samples a request must show before it is recognised, and this rejects short glitches.

Top module: `bus_grant_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `bg_n` is 1, `strobe_oe` is 1 and `core_hold` is 0, so the processor owns the bus.
- R2: Edge 1 is the first rising clock edge that samples `br_n` low, and `br_n` then stays low. With the default parameters (SYNC_STAGES=2, QUAL_CYCLES=2), `bg_n` goes low just after edge SYNC_STAGES+QUAL_CYCLES+1, which is edge 5.
- R3: `strobe_oe` goes low one clock before `bg_n` goes low, just after edge SYNC_STAGES+QUAL_CYCLES (edge 4 with the defaults).
- R4: `strobe_oe` is never 1 while `bg_n` is 0.
- R5: Edge L+1 is the first rising edge that samples `br_n` high again. `bg_n` returns to 1 just after edge L+SYNC_STAGES+1. `strobe_oe` returns to 1 one clock later.
- R6: A low pulse on `br_n` that is sampled by fewer than QUAL_CYCLES rising edges leaves all three outputs at their owned values.
- R7: A low pulse on `br_n` sampled by exactly QUAL_CYCLES rising edges drops `strobe_oe` for a single clock. `bg_n` never goes low, and the processor then takes the bus back.
- R8: `core_hold` is 1 exactly when `strobe_oe` is 0.
- R9: A request sampled low by L > QUAL_CYCLES edges keeps `bg_n` low for exactly L-QUAL_CYCLES clocks, so the shortest grant lasts one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_n | input | 1 | Raw active-low bus request, may be asynchronous |
| bg_n | output | 1 | Active-low bus grant |
| strobe_oe | output | 1 | 1 = processor drives memory selects and read/write strobes |
| core_hold | output | 1 | 1 = core must not use the external bus |

## Verification
A wrong ownership state shows up at the pins within one clock. Either the grant and the strobe enable overlap, or their edges come in the wrong order, and the bound ordering checks catch either case on that edge. A latency fault in the synchroniser or the qualifier moves the grant's falling edge by whole cycles. The bench finds this because it predicts every sampled cycle of `bg_n` and `strobe_oe` from the request length and the clock edge on which the request was first sampled.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [1:0] {
    ST_OWNED      = 2'd0,
    ST_RELEASING  = 2'd1,
    ST_GRANTED    = 2'd2,
    ST_RECLAIMING = 2'd3
  } brg_state_t;
endpackage

// File: rtl/brg_sync.sv
module brg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_raw,
  output logic req_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= ~req_n_raw;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], ~req_n_raw};
      end
    end
  endgenerate

  assign req_sync = chain[LAST];
endmodule

// File: rtl/brg_qualify.sv
module brg_qualify #(
  parameter int QUAL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  output logic recognised
);
  generate
    if (QUAL_CYCLES <= 1) begin : g_direct
      assign recognised = req_sync;
    end else begin : g_count
      localparam int CW = $clog2(QUAL_CYCLES);
      localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES - 1);
      logic [CW-1:0] run_len;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_len <= '0;
        else if (!req_sync)   run_len <= '0;
        else if (run_len != LIMIT) run_len <= run_len + 1'b1;
      end

      assign recognised = req_sync && (run_len == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/brg_fsm.sv
module brg_fsm
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic recognised,
  output logic bg_n,
  output logic strobe_oe,
  output logic core_hold
);
  brg_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OWNED:      if (recognised) state_nx = ST_RELEASING;
      ST_RELEASING:  state_nx = recognised ? ST_GRANTED : ST_OWNED;
      ST_GRANTED:    if (!recognised) state_nx = ST_RECLAIMING;
      ST_RECLAIMING: state_nx = ST_OWNED;
      default:       state_nx = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWNED;
    else        state <= state_nx;
  end

  assign bg_n      = (state != ST_GRANTED);
  assign strobe_oe = (state == ST_OWNED);
  assign core_hold = (state != ST_OWNED);
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic br_n,
  output logic bg_n,
  output logic strobe_oe,
  output logic core_hold
);
  logic req_sync;
  logic recognised;

  brg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_n_raw(br_n), .req_sync(req_sync)
  );

  brg_qualify #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .recognised(recognised)
  );

  brg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .recognised(recognised),
    .bg_n(bg_n), .strobe_oe(strobe_oe), .core_hold(core_hold)
  );
endmodule

// File: rtl/brg_checker.sv
module brg_checker (
  input logic clk,
  input logic rst_n,
  input logic bg_n,
  input logic strobe_oe,
  input logic core_hold
);
  // R4
  oe_vs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_oe |-> bg_n);

  // R3
  release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bg_n) |-> !$past(strobe_oe));

  // R5
  reclaim_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_n) |=> strobe_oe);

  // R7
  release_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_oe) |=> (!bg_n || strobe_oe));

  // R8
  hold_vs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_n |-> core_hold);
endmodule

bind bus_grant_ctrl brg_checker u_brg_checker (
  .clk(clk), .rst_n(rst_n), .bg_n(bg_n), .strobe_oe(strobe_oe), .core_hold(core_hold)
);

// File: tb/bus_grant_ctrl_bench.sv
`timescale 1ns/1ps
module bus_grant_ctrl_bench;
  localparam int S = 2;
  localparam int Q = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_n = 1'b1;
  logic bg_n, strobe_oe, core_hold;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bus_grant_ctrl #(.SYNC_STAGES(S), .QUAL_CYCLES(Q)) u_bus_grant_ctrl (
    .clk(clk), .rst_n(rst_n), .br_n(br_n),
    .bg_n(bg_n), .strobe_oe(strobe_oe), .core_hold(core_hold)
  );

  always #4 clk = ~clk;

  // expected grant after edge n for a request sampled low on edges 1..len
  function automatic logic exp_bg(int n, int len);
    if (len > Q && n >= S + Q + 1 && n <= len + S) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_oe(int n, int len);
    if (len == Q && n == S + Q) return 1'b0;
    if (len > Q && n >= S + Q && n <= len + S + 1) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_trial(int len);
    string tb, to;
    @(posedge clk);
    #(1 + $urandom % 6);
    br_n = 1'b0;
    for (int n = 1; n <= len + S + 6; n++) begin
      @(posedge clk);
      #1;
      if (len < Q)       begin tb = "R6"; to = "R6"; end
      else if (len == Q) begin tb = "R7"; to = "R7"; end
      else begin
        tb = (n <= len) ? "R2/R9" : "R5/R9";
        to = (n <= len) ? "R3" : "R5";
      end
      check(tb, bg_n, exp_bg(n, len));
      check(to, strobe_oe, exp_oe(n, len));
      check("R8", core_hold, !exp_oe(n, len));
      check("R4", strobe_oe && !bg_n, 1'b0);
      if (n == len) begin
        #(1 + $urandom % 5);
        br_n = 1'b1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1", bg_n, 1'b1);
    check("R1", strobe_oe, 1'b1);
    check("R1", core_hold, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", bg_n, 1'b1);
    check("R1", strobe_oe, 1'b1);
    check("R1", core_hold, 1'b0);
    // directed corners
    run_trial(1);        // R6 glitch
    run_trial(Q);        // R7 abort after release
    run_trial(Q + 1);    // R9 shortest grant
    run_trial(20);       // long ownership
    for (int t = 0; t < 60; t++) run_trial(1 + int'($urandom % 12));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule